// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the countdown timer of a per-processor interrupt controller. Software programs it through a small synchronous register port. An initial count starts the timer. A divide code picks a power-of-two prescale of the block clock. A control entry holds the interrupt vector, a mask bit and a choice between one-shot and repeating operation. The live count can be read back at any time.

When the count expires, the block emits a single-cycle request pulse together with the programmed 8-bit vector. That pulse goes to the interrupt priority logic, which is not part of this block. A repeating timer reloads itself and keeps generating pulses. A one-shot timer rests at zero after its single expiry. Any write to the initial count restarts the timer at once, including the prescaler phase.

Top module: `lit_timer`

## Requirements
- R1: Register offsets on `bus_addr` are: 0 control entry, 1 initial count, 2 current count, 3 divide code. After reset the control entry reads 0x0001_0000 (only the mask set), the other three registers read 0, and `irq_pulse` is low.
- R2: A write to the divide register keeps only write-data bits 3, 1 and 0 and stores them in those same positions. All other bits read back as zero.
- R3: The divide code is {bit3, bit1, bit0}. The count decrements once every 2^((code+1) mod 8) clocks, so code 111 ticks every clock, code 000 every 2 clocks and code 010 every 8 clocks.
- R4: In the control entry, bit 17 selects repeating mode (1) or one-shot mode (0), bit 16 masks the timer, and bits 7:0 hold the vector. All other bits read back as zero.
- R5: A write of N to the initial count loads the current count with N and restarts the prescaler phase. Ticks then fall on the D-th, 2D-th and later clocks after the write, where D is the divide period. Writes to the current-count offset are ignored.
- R6: One-shot mode: the count falls by one per tick down to 0. On tick N+1 a single request is raised, and the count then stays at 0.
- R7: Repeating mode: on the tick that finds the count at 0, the count reloads from the initial count and a request is raised. Requests therefore repeat every (N+1)·D clocks.
- R8: While the mask bit is set, no request is raised, but the count keeps running.
- R9: An initial count of 0 leaves the timer stopped. The count stays at 0 and no request is raised.
- R10: A request is an edge-type event: `irq_pulse` is high for exactly one clock, and `irq_vector` carries the vector that was programmed at expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_pulse | output | 1 | One-clock timer interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
A behavioural model predicts, on every clock, the live count and the request output. The timer is run under three divide codes (111, 000, 010). Because the first expiry falls at a different cycle for each code, a wrong bit gather in the code or a shift that is off by one is exposed. One-shot and repeating runs with the same count separate the stop-at-zero path from the reload path. A masked repeating run shows that the mask gates only the request and not the count. A reload in the middle of a count, a zero count and a write to the read-only offset each exercise a restart or ignore rule.

// File: rtl/lit_pkg.sv
`timescale 1ns/1ps
package lit_pkg;

   localparam int ADDR_W   = 2;
   localparam int DATA_W   = 32;
   localparam int VEC_W    = 8;
   localparam int SHIFT_W  = 3;
   localparam int BIT_REP  = 17;
   localparam int BIT_MASK = 16;

   typedef enum logic [ADDR_W-1:0] {
      SEL_ENTRY = 2'd0,
      SEL_INIT  = 2'd1,
      SEL_CURR  = 2'd2,
      SEL_DIV   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic             repeat_en;
      logic             masked;
      logic [VEC_W-1:0] vector;
   } entry_t;

   // shift amount: code plus one, wrapping in three bits
   function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
      return code + SHIFT_W'(1);
   endfunction

endpackage

// File: rtl/lit_regs.sv
`timescale 1ns/1ps
module lit_regs
   import lit_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output entry_t                entry,
   output logic [SHIFT_W-1:0]    div_code,
   output logic [CNT_W-1:0]      init_val,
   output logic                  load,
   output logic [CNT_W-1:0]      load_val
);

   logic wr_entry, wr_div;

   assign wr_entry = wr_en && (reg_sel_e'(addr) == SEL_ENTRY);
   assign wr_div   = wr_en && (reg_sel_e'(addr) == SEL_DIV);
   assign load     = wr_en && (reg_sel_e'(addr) == SEL_INIT);
   assign load_val = wdata[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry    <= '{repeat_en: 1'b0, masked: 1'b1, vector: '0};
         div_code <= '0;
         init_val <= '0;
      end else begin
         if (wr_entry) begin
            entry.repeat_en <= wdata[BIT_REP];
            entry.masked    <= wdata[BIT_MASK];
            entry.vector    <= wdata[VEC_W-1:0];
         end
         if (wr_div)
            div_code <= {wdata[3], wdata[1], wdata[0]};
         if (load)
            init_val <= load_val;
      end
   end

   assert_div_gather_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_div |=> div_code == {$past(wdata[3]), $past(wdata[1]), $past(wdata[0])});

   assert_entry_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_entry |=> (entry.repeat_en == $past(wdata[BIT_REP])) &&
                   (entry.masked == $past(wdata[BIT_MASK])));

endmodule

// File: rtl/lit_prescaler.sv
`timescale 1ns/1ps
module lit_prescaler
   import lit_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);

   localparam int PW  = (1 << SHIFT_W) - 1;
   localparam int PWX = PW + 1;

   logic [PW-1:0]  phase;
   logic [PWX-1:0] span;

   // low 'shift' bits of phase all ones -> period boundary
   assign span = (PWX'(1) << shift) - PWX'(1);
   assign tick = &(phase | ~span[PW-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         phase <= '0;
      else
         phase <= phase + PW'(1);
   end

   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && shift != '0 && !restart) |=> (!tick || shift == '0));

   assert_restart_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && $past(shift) != '0 && shift != '0) |=> !tick);

endmodule

// File: rtl/lit_counter.sv
`timescale 1ns/1ps
module lit_counter
   import lit_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_val,
   input  logic             tick,
   input  entry_t           entry,
   output logic [CNT_W-1:0] count,
   output logic             irq_pulse,
   output logic [VEC_W-1:0] irq_vector
);

   logic armed;
   logic expire;

   assign expire = armed && tick && (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         armed <= 1'b0;
      end else if (load) begin
         count <= load_val;
         armed <= |load_val;
      end else if (armed && tick) begin
         if (count == '0) begin
            if (entry.repeat_en)
               count <= init_val;
            else
               armed <= 1'b0;
         end else begin
            count <= count - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_pulse <= expire && !load && !entry.masked;
         if (expire)
            irq_vector <= entry.vector;
      end
   end

   assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !load) |=> $stable(count));

   assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !irq_pulse);

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

endmodule

// File: rtl/lit_timer.sv
`timescale 1ns/1ps
module lit_timer
   import lit_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int RD_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_pulse,
   output logic [7:0]        irq_vector
);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
      $error("lit_timer: CNT_W must lie in 2..32");
   end
   if (RD_REG != 0 && RD_REG != 1) begin : g_bad_rdreg
      $error("lit_timer: RD_REG must be 0 or 1");
   end

   entry_t             entry;
   logic [SHIFT_W-1:0] div_code;
   logic [CNT_W-1:0]   init_val, load_val, count;
   logic               load, tick;
   logic [DATA_W-1:0]  rd_mux;

   lit_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .entry    (entry),
      .div_code (div_code),
      .init_val (init_val),
      .load     (load),
      .load_val (load_val)
   );

   lit_prescaler u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .shift   (code_to_shift(div_code)),
      .tick    (tick)
   );

   lit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_val   (load_val),
      .init_val   (init_val),
      .tick       (tick),
      .entry      (entry),
      .count      (count),
      .irq_pulse  (irq_pulse),
      .irq_vector (irq_vector)
   );

   always_comb begin
      rd_mux = '0;
      case (reg_sel_e'(bus_addr))
         SEL_ENTRY: begin
            rd_mux[BIT_REP]     = entry.repeat_en;
            rd_mux[BIT_MASK]    = entry.masked;
            rd_mux[VEC_W-1:0]   = entry.vector;
         end
         SEL_INIT: rd_mux = DATA_W'(init_val);
         SEL_CURR: rd_mux = DATA_W'(count);
         SEL_DIV:  rd_mux = {28'd0, div_code[2], 1'b0, div_code[1], div_code[0]};
         default:  rd_mux = '0;
      endcase
   end

   if (RD_REG == 1) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   assert_mask_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      entry.masked |=> !irq_pulse);

endmodule

// File: tb/lit_timer_test.sv
`timescale 1ns/1ps
module lit_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pulse;
   logic [7:0]  irq_vector;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   lit_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pulse(irq_pulse), .irq_vector(irq_vector)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   bit          m_rep = 0, m_mask = 1, m_armed = 0, m_fire = 0, m_prev_fire = 0;
   logic [7:0]  m_vec = 0, m_fire_vec = 0;
   logic [2:0]  m_code = 0;
   logic [31:0] m_init = 0, m_cur = 0;
   longint      m_elapsed = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         int per;
         per = 1 << ((int'(m_code) + 1) % 8);
         m_prev_fire = m_fire;
         m_fire = 0;
         if (bus_wr && bus_addr == 2'd1) begin
            m_init = bus_wdata; m_cur = bus_wdata;
            m_armed = (bus_wdata != 0); m_elapsed = 0;
         end else begin
            m_elapsed++;
            if (m_armed && (m_elapsed % per) == 0) begin
               if (m_cur == 0) begin
                  m_fire = !m_mask;
                  m_fire_vec = m_vec;
                  if (m_rep) m_cur = m_init;
                  else       m_armed = 0;
               end else m_cur--;
            end
         end
         if (bus_wr && bus_addr == 2'd0) begin
            m_rep = bus_wdata[17]; m_mask = bus_wdata[16]; m_vec = bus_wdata[7:0];
         end
         if (bus_wr && bus_addr == 2'd3)
            m_code = {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
         // per-clock comparison
         chk(irq_pulse == m_fire, "R10 model pulse", irq_pulse, m_fire);
         if (m_fire)
            chk(irq_vector == m_fire_vec, "R10 model vector", irq_vector, m_fire_vec);
         if (m_fire && m_prev_fire)
            chk(0, "R10 double pulse", 1, 0);
         if (!bus_wr && bus_addr == 2'd2)
            chk(bus_rdata == m_cur, "R6 model count", bus_rdata, m_cur);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      bus_addr = a;
      #1;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
      bus_addr = 2'd2;
   endtask

   task automatic measure(input int maxc, output int first, output int cnt);
      first = -1; cnt = 0;
      for (int k = 1; k <= maxc; k++) begin
         @(negedge clk); #2;
         if (irq_pulse) begin
            cnt++;
            if (first < 0) first = k;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int first, cnt;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd_chk(2'd0, 32'h0001_0000, "R1 entry reset");
      rd_chk(2'd1, 32'h0, "R1 init reset");
      rd_chk(2'd2, 32'h0, "R1 count reset");
      rd_chk(2'd3, 32'h0, "R1 divide reset");
      chk(irq_pulse == 1'b0, "R1 no pulse", irq_pulse, 0);

      // R2 divide bit keep
      wr(2'd3, 32'hFFFF_FFFF);
      rd_chk(2'd3, 32'h0000_000B, "R2 divide keep all");
      wr(2'd3, 32'hFFFF_FFF4);
      rd_chk(2'd3, 32'h0, "R2 divide other bits");

      // R4 entry fields
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk(2'd0, 32'h0003_00FF, "R4 entry fields");
      wr(2'd0, 32'h0000_0041);
      rd_chk(2'd0, 32'h0000_0041, "R4 entry oneshot");

      // R3/R6 one-shot, code 111 -> every clock
      wr(2'd3, 32'h0000_000B);
      wr(2'd1, 32'd5);
      measure(20, first, cnt);
      chk(first == 6, "R6 oneshot first /1", first, 6);
      chk(cnt == 1, "R6 oneshot count", cnt, 1);
      rd_chk(2'd2, 32'h0, "R6 rests at zero");

      // R3 code 000 -> every 2 clocks
      wr(2'd3, 32'h0);
      wr(2'd1, 32'd3);
      measure(20, first, cnt);
      chk(first == 8, "R3 divide by 2", first, 8);

      // R3 code 010 -> every 8 clocks
      wr(2'd3, 32'h2);
      wr(2'd1, 32'd2);
      measure(40, first, cnt);
      chk(first == 24, "R3 divide by 8", first, 24);
      chk(cnt == 1, "R3 single at /8", cnt, 1);

      // R7 repeating, vector 0x77
      wr(2'd3, 32'hB);
      wr(2'd0, 32'h0002_0077);
      wr(2'd1, 32'd4);
      measure(16, first, cnt);
      chk(first == 5, "R7 first period", first, 5);
      chk(cnt == 3, "R7 repeat count", cnt, 3);

      // R8 masked: no pulse, count moves
      wr(2'd0, 32'h0003_0077);
      wr(2'd1, 32'd3);
      @(negedge clk); #1;
      #1 chk(bus_rdata == 32'd2, "R8 count runs masked", bus_rdata, 2);
      measure(20, first, cnt);
      chk(cnt == 0, "R8 masked silent", cnt, 0);

      // R5 restart mid-count
      wr(2'd0, 32'h0002_0033);
      wr(2'd1, 32'd10);
      repeat (4) @(negedge clk);
      wr(2'd1, 32'd10);
      measure(11, first, cnt);
      chk(first == 11, "R5 restart", first, 11);

      // R5 write to current count ignored
      wr(2'd0, 32'h0000_0033);
      wr(2'd1, 32'd2);
      measure(6, first, cnt);
      wr(2'd2, 32'h55);
      rd_chk(2'd2, 32'h0, "R5 count read-only");

      // R9 zero initial count
      wr(2'd0, 32'h0002_0033);
      wr(2'd1, 32'd0);
      measure(20, first, cnt);
      chk(cnt == 0, "R9 zero no pulse", cnt, 0);
      rd_chk(2'd2, 32'h0, "R9 count stays zero");

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule